// File: doc/BRIEF.md
# Range-Change Output Calibration Sequencer

This block keeps the trim DACs of a multi-channel analog output stage matched to the range each channel currently uses. After reset it fills an internal 128-word calibration table by issuing one read command per word to an external serial shifter. It then programs the trim DACs of every channel for that channel's stored range, which is the bipolar 10 V code 0 after reset.

Once start-up is complete, the block accepts output writes that carry a channel, a range code and a data word. It compares the requested range with the range last used on that channel. If the two match, the write is forwarded to the converter interface straight away. If they differ, the block records the new range and sends four trim-DAC commands through the shifter before it forwards the write. The writer is held off by `wr_ready` for the whole time the block is busy.

Top module: `cal_seq`

## Requirements
- R1: After reset `wr_ready` and `out_valid` are low, and the first commands are table reads (`cmd_op`=0) for addresses 0,1,…,127 in ascending order. Each read waits for its `rsp_valid` before the next read is issued, and the word returned is stored at that address.
- R2: Once the table is loaded, every channel is trimmed in ascending channel order with its stored range. After reset this range is code 0. The block issues 4 trim commands per channel, and `wr_ready` stays low until the last of them has been accepted.
- R3: A trim command (`cmd_op`=1) for channel c and range r carries `cmd_dac` = c/2. Let O be table word 7+2r+12c and G be the word after it. The four commands, in order, carry sub-channel 4·(c mod 2) plus 2, 3, 1 and 0, with values O[15:8], O[7:0], G[15:8] and G[7:0].
- R4: A write whose range equals the channel's stored range causes no trim command. `out_valid` is high for exactly one cycle, in the cycle after the write is accepted.
- R5: A write whose range differs from the channel's stored range stores the new range and issues the four R3 commands. `out_valid` is asserted in the cycle after the fourth command is accepted.
- R6: `out_ctrl` has bit 0 at 0 (no simultaneous update), bit 1 at 1 (enable) and the channel in bits 2 and up. Bits 7:6 are 3 for range codes 0 and 3, 2 for codes 1 and 4, and 0 for codes 2 and 5. Bit 8 is set for codes greater than 2. All other bits are 0.
- R7: `out_addr` = 0x08 + 2·channel and `out_data` equals the accepted write data.
- R8: `wr_ready` is low from the acceptance of a write until the forwarded write has been issued.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and all command fields stay unchanged.
- R10: Range state is kept per channel. A range change on one channel does not alter the stored range of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Output write request |
| wr_ready | output | 1 | Block idle, write accepted this cycle if valid |
| wr_chan | input | CH_W (3) | Output channel |
| wr_range | input | 3 | Range code 0..5 |
| wr_data | input | DATA_W (16) | Converter data |
| cmd_valid | output | 1 | Shifter command valid |
| cmd_ready | input | 1 | Shifter accepts command |
| cmd_op | output | 1 | 0 = table read, 1 = trim write |
| cmd_addr | output | IDX_W (7) | Table address for a read |
| cmd_dac | output | DAC_W (2) | Trim DAC number |
| cmd_sub | output | 3 | Trim DAC sub-channel |
| cmd_val | output | DATA_W/2 (8) | Trim value |
| rsp_valid | input | 1 | Read word available |
| rsp_data | input | DATA_W (16) | Read word |
| out_valid | output | 1 | Forwarded write, one-cycle pulse |
| out_ctrl | output | 16 | Converter control word |
| out_addr | output | 8 | Converter data register address |
| out_data | output | DATA_W (16) | Converter data |

## Verification
The bench holds its own copy of a random table and checks every trim command against the R3 formula. A design that swapped coarse and fine bytes, used the wrong sub-channel order or miscomputed the index would send at least one wrong value. Back-to-back writes that repeat a channel's range target the no-retrim path: a design that always re-trims shows extra commands and a late `out_valid`, and one that never re-trims shows none where four are due. Directed writes alternate between neighbouring channels so that range state leaking between channels shows up. Random `cmd_ready` stalls check that command fields hold steady and that reads keep their ascending addresses.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int RANGE_W = 3;

    typedef enum logic [2:0] {
        S_LOAD_REQ,
        S_LOAD_WAIT,
        S_TRIM,
        S_IDLE,
        S_FWD
    } seq_st_e;

    localparam logic CMD_READ = 1'b0;
    localparam logic CMD_TRIM = 1'b1;

    // sub-channel offset for each trim step: coarse off, fine off, coarse gain, fine gain
    function automatic logic [1:0] step_sub(input logic [1:0] step);
        case (step)
            2'd0:    return 2'd2;
            2'd1:    return 2'd3;
            2'd2:    return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    // span field of the converter control word
    function automatic logic [1:0] span_field(input logic [RANGE_W-1:0] rng);
        case (rng)
            3'd0, 3'd3: return 2'd3;
            3'd1, 3'd4: return 2'd2;
            default:    return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/cal_table.sv
module cal_table #(
    parameter int DEPTH = 128,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem_q [DEPTH];
    logic [AW-1:0] raddr_nx;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    always_comb begin
        raddr_nx = raddr + AW'(1);
        rdata_a  = mem_q[raddr];
        rdata_b  = mem_q[raddr_nx];
    end
endmodule

// File: rtl/cal_trimsel.sv
module cal_trimsel
    import cal_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 128,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int DAC_W = $clog2(NUM_CH / 2),
    localparam int IDX_W = $clog2(DEPTH),
    localparam int TV_W  = DATA_W / 2
) (
    input  logic [CH_W-1:0]    chan,
    input  logic [RANGE_W-1:0] rng,
    input  logic [1:0]         step,
    input  logic [DATA_W-1:0]  off_word,
    input  logic [DATA_W-1:0]  gain_word,
    output logic [IDX_W-1:0]   tbl_idx,
    output logic [DAC_W-1:0]   dac,
    output logic [2:0]         sub,
    output logic [TV_W-1:0]    val
);
    always_comb begin
        tbl_idx = IDX_W'(7) + IDX_W'({rng, 1'b0}) + IDX_W'(chan) * IDX_W'(12);
        dac     = chan[CH_W-1:1];
        sub     = {chan[0], step_sub(step)};
        case (step)
            2'd0:    val = off_word[DATA_W-1:TV_W];
            2'd1:    val = off_word[TV_W-1:0];
            2'd2:    val = gain_word[DATA_W-1:TV_W];
            default: val = gain_word[TV_W-1:0];
        endcase
    end
endmodule

// File: rtl/cal_outfmt.sv
module cal_outfmt
    import cal_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [CH_W-1:0]    chan,
    input  logic [RANGE_W-1:0] rng,
    output logic [15:0]        ctrl,
    output logic [7:0]         addr
);
    always_comb begin
        ctrl             = '0;
        ctrl[1]          = 1'b1;
        ctrl[2 +: CH_W]  = chan;
        ctrl[7:6]        = span_field(rng);
        ctrl[8]          = (rng > 3'd2);
        addr             = 8'h08 + {8'(chan), 1'b0}[7:0];
    end
endmodule

// File: rtl/cal_seq.sv
module cal_seq
    import cal_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int DATA_W    = 16,
    parameter int TBL_DEPTH = 128,
    localparam int CH_W  = $clog2(NUM_CH),
    localparam int DAC_W = $clog2(NUM_CH / 2),
    localparam int IDX_W = $clog2(TBL_DEPTH),
    localparam int TV_W  = DATA_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [CH_W-1:0]    wr_chan,
    input  logic [2:0]         wr_range,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic               cmd_op,
    output logic [IDX_W-1:0]   cmd_addr,
    output logic [DAC_W-1:0]   cmd_dac,
    output logic [2:0]         cmd_sub,
    output logic [TV_W-1:0]    cmd_val,
    input  logic               rsp_valid,
    input  logic [DATA_W-1:0]  rsp_data,
    output logic               out_valid,
    output logic [15:0]        out_ctrl,
    output logic [7:0]         out_addr,
    output logic [DATA_W-1:0]  out_data
);
    typedef struct packed {
        seq_st_e                         st;
        logic [IDX_W-1:0]                rd_idx;
        logic [CH_W-1:0]                 chan;
        logic [RANGE_W-1:0]              rng;
        logic [1:0]                      step;
        logic                            boot;
        logic [DATA_W-1:0]               data;
        logic [NUM_CH-1:0][RANGE_W-1:0]  ranges;
    } regs_t;

    regs_t q, d;
    logic               tbl_we;
    logic [IDX_W-1:0]   tbl_idx;
    logic [DATA_W-1:0]  off_word, gain_word;
    logic [DAC_W-1:0]   trim_dac;
    logic [2:0]         trim_sub;
    logic [TV_W-1:0]    trim_val;

    cal_table #(.DEPTH(TBL_DEPTH), .W(DATA_W)) i_table (
        .clk     (clk),
        .we      (tbl_we),
        .waddr   (q.rd_idx),
        .wdata   (rsp_data),
        .raddr   (tbl_idx),
        .rdata_a (off_word),
        .rdata_b (gain_word)
    );

    cal_trimsel #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .DEPTH(TBL_DEPTH)) i_trimsel (
        .chan      (q.chan),
        .rng       (q.rng),
        .step      (q.step),
        .off_word  (off_word),
        .gain_word (gain_word),
        .tbl_idx   (tbl_idx),
        .dac       (trim_dac),
        .sub       (trim_sub),
        .val       (trim_val)
    );

    cal_outfmt #(.NUM_CH(NUM_CH)) i_outfmt (
        .chan (q.chan),
        .rng  (q.rng),
        .ctrl (out_ctrl),
        .addr (out_addr)
    );

    always_comb begin
        d      = q;
        tbl_we = 1'b0;
        case (q.st)
            S_LOAD_REQ: begin
                if (cmd_ready) d.st = S_LOAD_WAIT;
            end
            S_LOAD_WAIT: begin
                if (rsp_valid) begin
                    tbl_we = 1'b1;
                    if (q.rd_idx == IDX_W'(TBL_DEPTH - 1)) begin
                        d.st   = S_TRIM;
                        d.chan = '0;
                        d.rng  = q.ranges[0];
                        d.step = '0;
                        d.boot = 1'b1;
                    end else begin
                        d.rd_idx = q.rd_idx + IDX_W'(1);
                        d.st     = S_LOAD_REQ;
                    end
                end
            end
            S_TRIM: begin
                if (cmd_ready) begin
                    d.step = q.step + 2'd1;
                    if (q.step == 2'd3) begin
                        if (!q.boot) begin
                            d.st = S_FWD;
                        end else if (q.chan == CH_W'(NUM_CH - 1)) begin
                            d.st   = S_IDLE;
                            d.boot = 1'b0;
                        end else begin
                            d.chan = q.chan + CH_W'(1);
                            d.rng  = q.ranges[q.chan + CH_W'(1)];
                        end
                    end
                end
            end
            S_IDLE: begin
                if (wr_valid) begin
                    d.chan = wr_chan;
                    d.rng  = wr_range;
                    d.data = wr_data;
                    if (wr_range != q.ranges[wr_chan]) begin
                        d.ranges[wr_chan] = wr_range;
                        d.step            = '0;
                        d.st              = S_TRIM;
                    end else begin
                        d.st = S_FWD;
                    end
                end
            end
            default: begin
                d.st = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_LOAD_REQ;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        wr_ready  = (q.st == S_IDLE);
        cmd_valid = (q.st == S_LOAD_REQ) || (q.st == S_TRIM);
        cmd_op    = (q.st == S_TRIM) ? CMD_TRIM : CMD_READ;
        cmd_addr  = q.rd_idx;
        cmd_dac   = trim_dac;
        cmd_sub   = trim_sub;
        cmd_val   = trim_val;
        out_valid = (q.st == S_FWD);
        out_data  = q.data;
    end

    // R9: a stalled command keeps its fields
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid &&
            $stable({cmd_op, cmd_addr, cmd_dac, cmd_sub, cmd_val}));

    // R4: the forwarded write is a single-cycle pulse and returns to idle
    p_fwd_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid && wr_ready);

    // R5: a range change starts trimming in the next cycle
    p_retrim_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && (wr_range != q.ranges[wr_chan]) |=> cmd_valid && cmd_op);

    // R5: last trim of a run-time retrim leads to the forwarded write
    p_trim_then_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_TRIM) && cmd_ready && (q.step == 2'd3) && !q.boot |=> out_valid);

    // R10: stored ranges only move when a write is accepted
    p_range_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_ready) |=> $stable(q.ranges));

    // R8: no write accepted while a command or forward is pending
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid || out_valid |-> !wr_ready);
endmodule

// File: tb/test_cal_seq.sv
module test_cal_seq;
    localparam int  NUM_CH  = 8;
    localparam int  DEPTH   = 128;
    localparam time CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [2:0]  wr_chan = '0;
    logic [2:0]  wr_range = '0;
    logic [15:0] wr_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic        cmd_op;
    logic [6:0]  cmd_addr;
    logic [1:0]  cmd_dac;
    logic [2:0]  cmd_sub;
    logic [7:0]  cmd_val;
    logic        rsp_valid = 1'b0;
    logic [15:0] rsp_data = '0;
    logic        out_valid;
    logic [15:0] out_ctrl;
    logic [7:0]  out_addr;
    logic [15:0] out_data;

    cal_seq i_cal_seq (.*);

    always #(CLK_PER / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] tbl [DEPTH];
    logic [2:0]  model_rng [NUM_CH];
    int   read_next = 0;
    int   trim_cnt  = 0;
    int   ctx_chan = 0, ctx_rng = 0, ctx_step = 0;
    bit   boot_phase = 1'b1;
    int   resp_delay = 0;
    int   resp_addr  = 0;
    bit   hold_pend  = 1'b0;
    logic [20:0] hold_sv;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_trim(input int c, input int r, input int s);
        int idx;
        logic [15:0] o, g;
        logic [2:0] base;
        logic [2:0] sb;
        logic [7:0] v;
        idx  = 7 + 2 * r + 12 * c;
        o    = tbl[idx];
        g    = tbl[idx + 1];
        base = 3'((c % 2) * 4);
        case (s)
            0:       begin sb = base + 3'd2; v = o[15:8]; end
            1:       begin sb = base + 3'd3; v = o[7:0];  end
            2:       begin sb = base + 3'd1; v = g[15:8]; end
            default: begin sb = base;        v = g[7:0];  end
        endcase
        return {2'(c / 2), sb, v};
    endfunction

    function automatic logic [15:0] exp_ctrl(input int c, input int r);
        logic [15:0] w;
        w = 16'h0002;
        w[4:2] = 3'(c);
        w[7:6] = (r % 3 == 0) ? 2'd3 : (r % 3 == 1) ? 2'd2 : 2'd0;
        w[8]   = (r > 2);
        return w;
    endfunction

    // shifter model and command checker
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend)
                chk(cmd_valid && ({cmd_op, cmd_addr, cmd_dac, cmd_sub, cmd_val} == hold_sv), "R9",
                    32'({cmd_op, cmd_addr, cmd_dac, cmd_sub, cmd_val}), 32'(hold_sv));
            rsp_valid = 1'b0;
            if (resp_delay > 0) begin
                resp_delay--;
                if (resp_delay == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = tbl[resp_addr];
                end
            end
            cmd_ready = ($urandom % 4) != 0;
            if (cmd_valid && cmd_ready) begin
                if (cmd_op == 1'b0) begin
                    chk(int'(cmd_addr) == read_next, "R1", 32'(cmd_addr), 32'(read_next));
                    resp_addr  = int'(cmd_addr);
                    resp_delay = 1 + int'($urandom % 3);
                    read_next++;
                end else begin
                    chk({cmd_dac, cmd_sub, cmd_val} == exp_trim(ctx_chan, ctx_rng, ctx_step),
                        boot_phase ? "R2/R3" : "R3", 32'({cmd_dac, cmd_sub, cmd_val}),
                        32'(exp_trim(ctx_chan, ctx_rng, ctx_step)));
                    trim_cnt++;
                    if (ctx_step == 3) begin
                        ctx_step = 0;
                        if (boot_phase && ctx_chan < NUM_CH - 1) ctx_chan++;
                    end else begin
                        ctx_step++;
                    end
                end
            end
            hold_pend = cmd_valid && !cmd_ready;
            hold_sv   = {cmd_op, cmd_addr, cmd_dac, cmd_sub, cmd_val};
        end
    end

    task automatic do_write(input int c, input int r, input logic [15:0] dat);
        bit retrim;
        int guard;
        @(negedge clk);
        retrim   = (3'(r) != model_rng[c]);
        ctx_chan = c; ctx_rng = r; ctx_step = 0; trim_cnt = 0;
        wr_valid = 1'b1; wr_chan = 3'(c); wr_range = 3'(r); wr_data = dat;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        if (!retrim) begin
            chk(out_valid && trim_cnt == 0, "R4", 32'({out_valid, 8'(trim_cnt)}), 32'h100);
        end else begin
            guard = 0;
            while (!out_valid && guard < 200) begin
                chk(!wr_ready, "R8", 32'(wr_ready), 32'h0);
                @(negedge clk);
                guard++;
            end
            chk(out_valid && trim_cnt == 4, "R5", 32'(trim_cnt), 32'h4);
        end
        if (out_valid) begin
            chk(out_ctrl == exp_ctrl(c, r), "R6", 32'(out_ctrl), 32'(exp_ctrl(c, r)));
            chk(out_addr == 8'(8 + 2 * c) && out_data == dat, "R7",
                32'({out_addr, out_data}), 32'({8'(8 + 2 * c), dat}));
        end
        model_rng[c] = 3'(r);
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        for (int i = 0; i < DEPTH; i++) tbl[i] = 16'($urandom);
        for (int i = 0; i < NUM_CH; i++) model_rng[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_ready && !out_valid, "R1", 32'({wr_ready, out_valid}), 32'h0);
        begin
            int guard = 0;
            while (!wr_ready && guard < 20000) begin @(negedge clk); guard++; end
        end
        chk(read_next == DEPTH, "R1", 32'(read_next), 32'(DEPTH));
        chk(trim_cnt == 4 * NUM_CH && ctx_chan == NUM_CH - 1, "R2", 32'(trim_cnt), 32'(4 * NUM_CH));
        boot_phase = 1'b0;

        // directed corners
        do_write(0, 0, 16'h1234);       // R4: same range as boot
        do_write(1, 4, 16'hABCD);       // R5: unipolar 5 V retrim
        do_write(2, 0, 16'h0F0F);       // R10: neighbour untouched
        do_write(1, 4, 16'h5555);       // R10: range kept
        do_write(7, 5, 16'hFFFF);       // R3: top channel, top range
        do_write(6, 2, 16'h0001);
        do_write(7, 5, 16'h8000);
        // random mix
        for (int k = 0; k < 150; k++) begin
            int c, r;
            c = int'($urandom % NUM_CH);
            r = ($urandom % 2 == 0) ? int'(model_rng[c]) : int'($urandom % 6);
            do_write(c, r, 16'($urandom));
        end
        repeat (3) @(negedge clk);
        chk(!out_valid && wr_ready, "R4", 32'({out_valid, wr_ready}), 32'h1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule